// File: doc/BRIEF.md
# Way-Chopable Second-Level Cache Tag Controller

This block is the tag side of an 8-way set-associative second-level cache. Each set keeps one combined record that holds the tags of all ways, a 2-bit line state per way and the pseudo-LRU tree bits. The record is read and written back as a whole. A read or write request names a set and a tag. The block answers with hit or miss and a way. On a hit the way is the matching way. On a miss it is the chosen victim, which the block fills with the new tag at once. It also reports whether that victim held a valid line, whether the line was dirty, and which tag it held. The record is read on the edge that accepts a request. The next cycle compares tags and writes the record back, and the response register is loaded on that same edge. A new request can therefore be accepted on every cycle. When two requests touch the same set back to back, the second one uses the updated record that the first one is still writing.

The number of active ways can be lowered at run time to 4 or 2, and raised again. Active ways are always ways 0 to N-1. When the active set shrinks, the block first walks every set. It hands each modified line found in a way being switched off to a write-back stream, and it invalidates every line in those ways. Only then does it apply the new way count. Each inactive way has a power-down enable output. The data array, the error-correction datapath and the bus side sit outside this block. They use the way number and the eviction report.

Request, response and write-back channels all use valid/ready. A request is taken on an edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a response is waiting on a low `resp_ready`, during a flush walk, and while an accepted chop request waits for the pipeline to drain. A response or write-back item stays on its outputs, unchanged, until its ready is seen high at a clock edge.

Top module: `l2tag_ctrl`

## Requirements
- R1: A request accepted at clock edge k produces a response at edge k+1, provided `resp_ready` was high. Responses come out in request order, and back-to-back requests are accepted on consecutive edges.
- R2: A hit is reported only when an active way holds a non-invalid line with the requested tag, and `resp_way` then names that way. A read hit leaves the line state unchanged. A write hit makes the line modified.
- R3: On a miss, the victim is the lowest-numbered invalid active way. When every active way is valid, the victim comes from a heap-ordered tree of NWAYS-1 bits. Node n has children 2n+1 (left, lower ways) and 2n+2. A bit of 0 steers the victim left. With 8>>s active ways, the search starts at node 2^s-1. Every access sets each bit on the path to the accessed way so that it points away from that way.
- R4: On a miss, `resp_evict` is high exactly when the victim held a valid line. `resp_dirty` is high when that line was modified, and `resp_evict_tag` gives its tag. The victim is refilled with the request tag, as exclusive for a read and as modified for a write.
- R5: A request to the same set as the request accepted one edge earlier sees that earlier request's updated tags, states and tree bits.
- R6: `cfg_shift` selects 8>>cfg_shift active ways: 0 selects 8, 1 selects 4, 2 selects 2. A chop request with value 3 is ignored: `chop_done` stays low, `req_ready` stays high and `way_pd` keeps its value.
- R7: Chop handshake. `chop_req` is a level. Requests are blocked from acceptance of the chop until the walk ends. The new way count takes effect on the edge that raises `chop_done`. `chop_done` stays high until `chop_req` is dropped, and falls on the following edge.
- R8: When shrinking, every set is visited. Each modified line in a way being disabled is offered once on the write-back channel, with its set, way and tag. All lines in the disabled ways become invalid, so they miss later when their ways are re-enabled.
- R9: `way_pd[i]` is 1 exactly when way i is inactive. An inactive way never hits and is never returned as a victim.
- R10: After reset, all lines are invalid, all tree bits are 0, 8 ways are active, `way_pd` is 0, `resp_valid`, `wb_valid` and `chop_done` are low, and `req_ready` is high.
- R11: While `resp_valid` is high and `resp_ready` is low, the response fields hold their values and no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_set | input | 4 | Set index |
| req_tag | input | 8 | Tag to look up |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Response consumer ready |
| resp_hit | output | 1 | Lookup hit |
| resp_way | output | 3 | Hit way or filled victim way |
| resp_evict | output | 1 | Victim held a valid line |
| resp_dirty | output | 1 | Victim line was modified |
| resp_evict_tag | output | 8 | Tag of the evicted line |
| cfg_shift | input | 2 | Active way count select (8>>value) |
| chop_req | input | 1 | Apply `cfg_shift` (level) |
| chop_done | output | 1 | Reconfiguration complete |
| wb_valid | output | 1 | Dirty line from a disabled way offered |
| wb_ready | input | 1 | Write-back consumer ready |
| wb_set | output | 4 | Set of the offered line |
| wb_way | output | 3 | Way of the offered line |
| wb_tag | output | 8 | Tag of the offered line |
| way_pd | output | 8 | Per-way power-down enable |

## Verification
On every cycle, the embedded assertions check the following. At most one active way matches a tag. Victims and hits stay inside the enabled ways. Stalled response and write-back items hold still. A walk blocks requests, `chop_done` holds while the request is held, and the way mask changes only as `chop_done` rises. Write-back items come only from ways being disabled. Only the bench scenarios can show that the chosen victims follow the tree order, that back-to-back updates to one set are forwarded, that eviction tags and dirty flags are correct, and that a shrink reports each dirty line once and leaves the disabled ways empty when they come back.

// File: rtl/l2tag_pkg.sv
package l2tag_pkg;
  localparam int NWAYS   = 8;
  localparam int TAG_W   = 8;
  localparam int SET_W   = 4;
  localparam int NSETS   = 1 << SET_W;
  localparam int WAY_W   = $clog2(NWAYS);
  localparam int LVL     = WAY_W;
  localparam int SHIFT_W = 2;
  localparam int MAX_SHIFT = LVL - 1;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_st_e;

  // one combined record per set: tags, states and tree bits together
  typedef struct packed {
    logic [NWAYS-1:0][TAG_W-1:0] tag;
    logic [NWAYS-1:0][1:0]       st;
    logic [NWAYS-2:0]            plru;
  } set_ent_t;

  function automatic int act_ways(input logic [SHIFT_W-1:0] s);
    return NWAYS >> s;
  endfunction
endpackage

// File: rtl/l2tag_plru.sv
module l2tag_plru
  import l2tag_pkg::*;
(
  input  logic [NWAYS-2:0]   bits_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [WAY_W-1:0]   touch_i,
  output logic [WAY_W-1:0]   victim_o,
  output logic [NWAYS-2:0]   bits_o
);
  // victim search starts at the root of the subtree that covers the active ways
  always_comb begin
    int n;
    n = (1 << shift_i) - 1;
    for (int lv = 0; lv < LVL; lv++) begin
      if (lv >= int'(shift_i)) n = 2 * n + 1 + int'(bits_i[n]);
    end
    victim_o = WAY_W'(n - (NWAYS - 1));
  end

  // every node on the path to the touched way is turned away from it
  always_comb begin
    bits_o = bits_i;
    for (int lv = 0; lv < LVL; lv++) begin
      int n;
      n = (1 << lv) - 1 + (int'(touch_i) >> (LVL - lv));
      bits_o[n] = ~touch_i[LVL-1-lv];
    end
  end
endmodule

// File: rtl/l2tag_lookup.sv
module l2tag_lookup
  import l2tag_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chk_en,
  input  set_ent_t           ent_i,
  input  logic [TAG_W-1:0]   tag_i,
  input  logic               wr_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               hit_o,
  output logic [WAY_W-1:0]   way_o,
  output logic               ev_o,
  output logic               dirty_o,
  output logic [TAG_W-1:0]   evtag_o,
  output set_ent_t           ent_o
);
  logic [NWAYS-1:0] act, match, free;
  logic [WAY_W-1:0] hit_way, free_way, plru_vic;
  logic [NWAYS-2:0] plru_nx;
  logic             has_free;

  always_comb begin
    for (int i = 0; i < NWAYS; i++) begin
      act[i]   = (i < act_ways(shift_i));
      match[i] = act[i] && (ent_i.st[i] != LS_INV) && (ent_i.tag[i] == tag_i);
      free[i]  = act[i] && (ent_i.st[i] == LS_INV);
    end
  end

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int i = NWAYS - 1; i >= 0; i--) begin
      if (match[i]) hit_way  = WAY_W'(i);
      if (free[i])  free_way = WAY_W'(i);
    end
  end

  assign hit_o    = |match;
  assign has_free = |free;
  assign way_o    = hit_o ? hit_way : (has_free ? free_way : plru_vic);
  assign ev_o     = !hit_o && !has_free;
  assign dirty_o  = ev_o && (ent_i.st[way_o] == LS_MOD);
  assign evtag_o  = ent_i.tag[way_o];

  l2tag_plru u_plru (
    .bits_i   (ent_i.plru),
    .shift_i  (shift_i),
    .touch_i  (way_o),
    .victim_o (plru_vic),
    .bits_o   (plru_nx)
  );

  always_comb begin
    ent_o      = ent_i;
    ent_o.plru = plru_nx;
    if (hit_o) begin
      if (wr_i) ent_o.st[way_o] = LS_MOD;
    end else begin
      ent_o.tag[way_o] = tag_i;
      ent_o.st[way_o]  = wr_i ? LS_MOD : LS_EXC;
    end
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> $onehot0(match)); // R2
  AST_WAY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> act[way_o]); // R9
endmodule

// File: rtl/l2tag_flush.sv
module l2tag_flush
  import l2tag_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          chop_req_i,
  input  logic [SHIFT_W-1:0]            cfg_shift_i,
  input  logic                          pipe_idle_i,
  input  logic [NWAYS-1:0][TAG_W-1:0]   rd_tag_i,
  input  logic [NWAYS-1:0][1:0]         rd_st_i,
  input  logic                          wb_ready_i,
  output logic [SET_W-1:0]              walk_set_o,
  output logic [WAY_W-1:0]              walk_way_o,
  output logic                          inv_o,
  output logic                          wb_valid_o,
  output logic [SET_W-1:0]              wb_set_o,
  output logic [WAY_W-1:0]              wb_way_o,
  output logic [TAG_W-1:0]              wb_tag_o,
  output logic                          busy_o,
  output logic                          hold_o,
  output logic                          done_o,
  output logic [SHIFT_W-1:0]            act_shift_o
);
  typedef enum logic [1:0] {FL_IDLE, FL_WALK, FL_WB, FL_DONE} fl_st_e;

  fl_st_e             fsm;
  logic [SHIFT_W-1:0] cur_shift, new_shift;
  logic [SET_W-1:0]   wset;
  logic [WAY_W-1:0]   wway;
  logic               shift_ok, dirty, step, last_way, last_set;

  assign shift_ok = cfg_shift_i <= SHIFT_W'(MAX_SHIFT);
  assign dirty    = rd_st_i[wway] == LS_MOD;
  assign step     = (fsm == FL_WALK && !dirty) || (fsm == FL_WB && wb_ready_i);
  assign last_way = int'(wway) == act_ways(cur_shift) - 1;
  assign last_set = int'(wset) == NSETS - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm       <= FL_IDLE;
      cur_shift <= '0;
      new_shift <= '0;
      wset      <= '0;
      wway      <= '0;
    end else begin
      case (fsm)
        FL_IDLE: begin
          if (chop_req_i && shift_ok && pipe_idle_i) begin
            new_shift <= cfg_shift_i;
            wset      <= '0;
            wway      <= WAY_W'(act_ways(cfg_shift_i));
            if (cfg_shift_i <= cur_shift) begin
              cur_shift <= cfg_shift_i;
              fsm       <= FL_DONE;
            end else begin
              fsm <= FL_WALK;
            end
          end
        end
        FL_WALK, FL_WB: begin
          if (fsm == FL_WALK && dirty) fsm <= FL_WB;
          if (step) begin
            if (last_way) begin
              wway <= WAY_W'(act_ways(new_shift));
              if (last_set) begin
                cur_shift <= new_shift;
                fsm       <= FL_DONE;
              end else begin
                wset <= wset + SET_W'(1);
                fsm  <= FL_WALK;
              end
            end else begin
              wway <= wway + WAY_W'(1);
              fsm  <= FL_WALK;
            end
          end
        end
        FL_DONE: if (!chop_req_i) fsm <= FL_IDLE;
        default: fsm <= FL_IDLE;
      endcase
    end
  end

  assign walk_set_o  = wset;
  assign walk_way_o  = wway;
  assign inv_o       = step;
  assign wb_valid_o  = fsm == FL_WB;
  assign wb_set_o    = wset;
  assign wb_way_o    = wway;
  assign wb_tag_o    = rd_tag_i[wway];
  assign busy_o      = (fsm == FL_WALK) || (fsm == FL_WB);
  assign hold_o      = busy_o || (fsm == FL_IDLE && chop_req_i && shift_ok);
  assign done_o      = fsm == FL_DONE;
  assign act_shift_o = cur_shift;

  AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o && !wb_ready_i |=> wb_valid_o && $stable(wb_set_o) && $stable(wb_way_o) && $stable(wb_tag_o)); // R8
  AST_WB_FROM_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid_o |-> int'(wb_way_o) >= act_ways(new_shift)); // R8
  AST_MASK_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_shift) |-> done_o); // R7
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && chop_req_i |=> done_o); // R7
endmodule

// File: rtl/l2tag_ctrl.sv
module l2tag_ctrl
  import l2tag_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [SET_W-1:0]   req_set,
  input  logic [TAG_W-1:0]   req_tag,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic               resp_hit,
  output logic [WAY_W-1:0]   resp_way,
  output logic               resp_evict,
  output logic               resp_dirty,
  output logic [TAG_W-1:0]   resp_evict_tag,
  input  logic [SHIFT_W-1:0] cfg_shift,
  input  logic               chop_req,
  output logic               chop_done,
  output logic               wb_valid,
  input  logic               wb_ready,
  output logic [SET_W-1:0]   wb_set,
  output logic [WAY_W-1:0]   wb_way,
  output logic [TAG_W-1:0]   wb_tag,
  output logic [NWAYS-1:0]   way_pd
);
  set_ent_t arr [NSETS];

  // stage 1: record captured on acceptance
  logic               s1_valid, s1_write;
  logic [SET_W-1:0]   s1_set;
  logic [TAG_W-1:0]   s1_tag;
  set_ent_t           s1_ent;

  // response register
  logic               rv_q, rhit_q, rev_q, rdirty_q;
  logic [WAY_W-1:0]   rway_q;
  logic [TAG_W-1:0]   retag_q;

  logic               adv, acc, lk_we;
  logic               lk_hit, lk_ev, lk_dirty;
  logic [WAY_W-1:0]   lk_way;
  logic [TAG_W-1:0]   lk_etag;
  set_ent_t           lk_ent;

  logic               fl_inv, fl_busy, fl_hold;
  logic [SET_W-1:0]   fl_set;
  logic [WAY_W-1:0]   fl_way;
  logic [SHIFT_W-1:0] act_shift;

  assign adv       = !rv_q || resp_ready;
  assign req_ready = adv && !fl_hold;
  assign acc       = req_valid && req_ready;
  assign lk_we     = s1_valid && adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      rv_q     <= 1'b0;
    end else if (adv) begin
      s1_valid <= acc;
      rv_q     <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      if (acc) begin
        s1_write <= req_write;
        s1_set   <= req_set;
        s1_tag   <= req_tag;
        // same set still being written: take the updated record
        s1_ent   <= (s1_valid && s1_set == req_set) ? lk_ent : arr[req_set];
      end
      if (s1_valid) begin
        rhit_q   <= lk_hit;
        rway_q   <= lk_way;
        rev_q    <= lk_ev;
        rdirty_q <= lk_dirty;
        retag_q  <= lk_etag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSETS; s++) arr[s] <= '0;
    end else if (lk_we) begin
      arr[s1_set] <= lk_ent;
    end else if (fl_inv) begin
      arr[fl_set].st[fl_way] <= LS_INV;
    end
  end

  l2tag_lookup u_lookup (
    .clk     (clk),
    .rst_n   (rst_n),
    .chk_en  (s1_valid),
    .ent_i   (s1_ent),
    .tag_i   (s1_tag),
    .wr_i    (s1_write),
    .shift_i (act_shift),
    .hit_o   (lk_hit),
    .way_o   (lk_way),
    .ev_o    (lk_ev),
    .dirty_o (lk_dirty),
    .evtag_o (lk_etag),
    .ent_o   (lk_ent)
  );

  l2tag_flush u_flush (
    .clk         (clk),
    .rst_n       (rst_n),
    .chop_req_i  (chop_req),
    .cfg_shift_i (cfg_shift),
    .pipe_idle_i (!s1_valid && !rv_q),
    .rd_tag_i    (arr[fl_set].tag),
    .rd_st_i     (arr[fl_set].st),
    .wb_ready_i  (wb_ready),
    .walk_set_o  (fl_set),
    .walk_way_o  (fl_way),
    .inv_o       (fl_inv),
    .wb_valid_o  (wb_valid),
    .wb_set_o    (wb_set),
    .wb_way_o    (wb_way),
    .wb_tag_o    (wb_tag),
    .busy_o      (fl_busy),
    .hold_o      (fl_hold),
    .done_o      (chop_done),
    .act_shift_o (act_shift)
  );

  always_comb begin
    for (int i = 0; i < NWAYS; i++) way_pd[i] = !(i < act_ways(act_shift));
  end

  assign resp_valid     = rv_q;
  assign resp_hit       = rhit_q;
  assign resp_way       = rway_q;
  assign resp_evict     = rev_q;
  assign resp_dirty     = rdirty_q;
  assign resp_evict_tag = retag_q;

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_way) && $stable(resp_hit) && $stable(resp_evict_tag)); // R11
  AST_NO_ACCEPT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |-> !req_ready); // R11
  AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !way_pd[resp_way]); // R9
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    fl_busy |-> !req_ready); // R7
endmodule

// File: tb/sim_l2tag_ctrl.sv
module sim_l2tag_ctrl;
  import l2tag_pkg::*;

  typedef struct packed {
    logic             wr;
    logic [SET_W-1:0] set;
    logic [TAG_W-1:0] tag;
    logic             hit;
    logic [WAY_W-1:0] way;
    logic             ev;
    logic             dirty;
    logic [TAG_W-1:0] etag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd0, 8'h10, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00},
    '{1'b0, 4'd0, 8'h10, 1'b1, 3'd0, 1'b0, 1'b0, 8'h00},
    '{1'b1, 4'd0, 8'h11, 1'b0, 3'd1, 1'b0, 1'b0, 8'h00},
    '{1'b1, 4'd0, 8'h10, 1'b1, 3'd0, 1'b0, 1'b0, 8'h00},
    '{1'b0, 4'd1, 8'h10, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00},
    '{1'b0, 4'd0, 8'h12, 1'b0, 3'd2, 1'b0, 1'b0, 8'h00},
    '{1'b0, 4'd0, 8'h13, 1'b0, 3'd3, 1'b0, 1'b0, 8'h00},
    '{1'b0, 4'd0, 8'h14, 1'b0, 3'd4, 1'b0, 1'b0, 8'h00},
    '{1'b0, 4'd0, 8'h15, 1'b0, 3'd5, 1'b0, 1'b0, 8'h00},
    '{1'b0, 4'd0, 8'h16, 1'b0, 3'd6, 1'b0, 1'b0, 8'h00},
    '{1'b1, 4'd0, 8'h17, 1'b0, 3'd7, 1'b0, 1'b0, 8'h00},
    '{1'b0, 4'd0, 8'h20, 1'b0, 3'd1, 1'b1, 1'b1, 8'h11},
    '{1'b0, 4'd0, 8'h11, 1'b0, 3'd4, 1'b1, 1'b0, 8'h14},
    '{1'b1, 4'd0, 8'h20, 1'b1, 3'd1, 1'b0, 1'b0, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, resp_ready = 1'b1;
  logic [SET_W-1:0] req_set = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [SHIFT_W-1:0] cfg_shift = '0;
  logic chop_req = 1'b0, wb_ready = 1'b0;
  logic req_ready, resp_valid, resp_hit, resp_evict, resp_dirty, chop_done, wb_valid;
  logic [WAY_W-1:0] resp_way, wb_way;
  logic [TAG_W-1:0] resp_evict_tag, wb_tag;
  logic [SET_W-1:0] wb_set;
  logic [NWAYS-1:0] way_pd;

  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  l2tag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_set(req_set), .req_tag(req_tag),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_hit(resp_hit),
    .resp_way(resp_way), .resp_evict(resp_evict), .resp_dirty(resp_dirty),
    .resp_evict_tag(resp_evict_tag), .cfg_shift(cfg_shift), .chop_req(chop_req),
    .chop_done(chop_done), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_set(wb_set), .wb_way(wb_way), .wb_tag(wb_tag), .way_pd(way_pd)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic check_resp(input vec_t v, input string hit_rq);
    chk("R1 valid", resp_valid, 1);
    chk(hit_rq, resp_hit, v.hit);
    chk("R3 way", resp_way, v.way);
    chk("R4 evict", resp_evict, v.ev);
    chk("R4 dirty", resp_dirty, v.dirty);
    if (v.ev) chk("R4 evict tag", resp_evict_tag, v.etag);
  endtask

  task automatic one_req(input vec_t v, input string hit_rq);
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_set = v.set; req_tag = v.tag;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check_resp(v, hit_rq);
  endtask

  task automatic wait_done(output int wbs);
    int k;
    k = 0; wbs = 0;
    while (!chop_done && k < 2000) begin
      @(negedge clk);
      if (wb_valid && wb_ready) wbs++;
      k++;
    end
  endtask

  task automatic release_chop();
    chop_req = 1'b0;
    @(negedge clk);
    chk("R7 done falls", chop_done, 0);
  endtask

  initial begin
    #(20 * 100000);
    nerr++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int wbs, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 resp_valid", resp_valid, 0);
    chk("R10 way_pd", way_pd, 8'h00);
    chk("R10 req_ready", req_ready, 1);
    chk("R10 chop_done", chop_done, 0);
    chk("R10 wb_valid", wb_valid, 0);

    // table: one request per cycle, responses checked two negedges later (R1)
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) check_resp(VEC[i-2], (i-2 == 1 || i-2 >= 11) ? "R5 fwd" : "R2 hit");
      if (i < NV) begin
        req_valid = 1'b1; req_write = VEC[i].wr; req_set = VEC[i].set; req_tag = VEC[i].tag;
      end else begin
        req_valid = 1'b0;
      end
    end

    // R11 response back-pressure
    @(negedge clk);
    resp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_set = 4'd2; req_tag = 8'h30;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R11 resp held valid", resp_valid, 1);
    chk("R11 no accept", req_ready, 0);
    repeat (3) @(negedge clk);
    chk("R11 still valid", resp_valid, 1);
    chk("R11 way held", resp_way, 0);
    resp_ready = 1'b1;
    @(negedge clk);
    chk("R11 drained", resp_valid, 0);

    // R8 shrink to 4 ways: one dirty line at set 0 way 7
    cfg_shift = 2'd1; chop_req = 1'b1; wb_ready = 1'b0;
    k = 0;
    while (!wb_valid && k < 2000) begin @(negedge clk); k++; end
    chk("R7 blocked during walk", req_ready, 0);
    chk("R8 wb set", wb_set, 0);
    chk("R8 wb way", wb_way, 7);
    chk("R8 wb tag", wb_tag, 8'h17);
    repeat (3) @(negedge clk);
    chk("R8 wb held", wb_valid, 1);
    chk("R8 wb tag held", wb_tag, 8'h17);
    wb_ready = 1'b1;
    @(negedge clk);
    wait_done(wbs);
    chk("R8 single report", wbs, 0);
    chk("R7 done", chop_done, 1);
    chk("R9 pd 4 ways", way_pd, 8'hF0);
    repeat (2) @(negedge clk);
    chk("R7 done holds", chop_done, 1);
    release_chop();

    // R9 disabled way 7 cannot hit; R3 tree restricted to ways 0..3
    one_req('{1'b0, 4'd0, 8'h17, 1'b0, 3'd2, 1'b1, 1'b0, 8'h12}, "R9 no hit");
    one_req('{1'b0, 4'd0, 8'h15, 1'b0, 3'd0, 1'b1, 1'b1, 8'h10}, "R9 no hit");
    one_req('{1'b0, 4'd0, 8'h20, 1'b1, 3'd1, 1'b0, 1'b0, 8'h00}, "R2 hit");

    // R6 invalid setting is ignored
    @(negedge clk);
    cfg_shift = 2'd3; chop_req = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 no done", chop_done, 0);
    chk("R6 ready", req_ready, 1);
    chk("R6 pd kept", way_pd, 8'hF0);
    chop_req = 1'b0;

    // R6 shrink to 2 ways, no dirty lines in ways 2..3
    @(negedge clk);
    cfg_shift = 2'd2; chop_req = 1'b1;
    @(negedge clk);
    chk("R7 blocked", req_ready, 0);
    wait_done(wbs);
    chk("R8 no reports", wbs, 0);
    chk("R6 pd 2 ways", way_pd, 8'hFC);
    release_chop();

    // R6 grow back to 8 ways
    cfg_shift = 2'd0; chop_req = 1'b1;
    wait_done(wbs);
    chk("R6 pd 8 ways", way_pd, 8'h00);
    release_chop();

    // R8 disabled ways came back empty
    one_req('{1'b0, 4'd0, 8'h17, 1'b0, 3'd2, 1'b0, 1'b0, 8'h00}, "R8 miss");
    one_req('{1'b0, 4'd0, 8'h13, 1'b0, 3'd3, 1'b0, 1'b0, 8'h00}, "R8 miss");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule